// File: doc/BRIEF.md
# Dual-Word Store Execution Unit

This block executes one immediate-offset store of a register pair. It takes an instruction word that has already been fetched, in either a 32-bit conditional format or a wide two-halfword format, and decodes the fields it needs. It reads the two data registers and the base register through three read ports, and forms the effective address from the base and an unsigned immediate. It then writes the pair to memory on a request/acknowledge store port and, for the pre-indexed and post-indexed modes, writes the updated base back to the register file.

Encodings that do not belong to this store are reported as bad. Register combinations with no defined result are reported as unpredictable. In both cases, and when the externally supplied condition-passed input is low, the block makes no memory write and no base update. The upstream pipeline offers one instruction at a time with a valid/ready handshake. The register file answers a read in the same cycle as the index, and the store port acknowledges each request when it is ready.

Top module: `pairstore_unit`

## Requirements
- R1: `in_ready` is high only while the unit is idle, and an instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. While an instruction is in progress, `in_ready` is low and `mem_req` is never high while `in_ready` is high.
- R2: Mode bits are word bit 24 (P) and bit 21 (W). P=1/W=0 is offset with no base update, and P=1/W=1 is pre-indexed with a base update. Post-indexed with a base update is P=0/W=0 in the 32-bit format and P=0/W=1 in the wide format.
- R3: The immediate in the 32-bit format is bits 11:8 joined above bits 3:0, zero-extended (0 to 255). In the wide format it is bits 7:0 multiplied by four (0 to 1020).
- R4: Bit 23 (U) set adds the immediate to the base and clear subtracts it. The access address is that offset address when P=1 and the unmodified base when P=0. A base update writes the offset address.
- R5: An access address with its low three bits zero gives one 64-bit write (`mem_dword`=1, `mem_be`=FF). With `in_big_endian` low, the first register is in data bits 31:0 and the second in bits 63:32; with `in_big_endian` high the halves are swapped.
- R6: Any other access address gives two 32-bit writes (`mem_dword`=0, `mem_be`=0F, data bits 63:32 zero). The first register goes to the address, then the second register goes to the address plus 4. The second request appears only after the first is acknowledged.
- R7: `op_done` pulses in the cycle after the last write acknowledge. A base update (`wb_en`, `wb_idx`, `wb_data`) is given in that same cycle and in no other.
- R8: `flag_bad_enc` pulses with `op_done`, with no write and no base update, when any of these holds:
  - 32-bit format: bits 31:28 are 1111; or bits 27:25 are not 000; or bit 22 is not 1; or bit 20 is not 0; or bits 7:4 are not 1111.
  - Wide format: bits 31:25 are not 1110100; or bit 22 is not 1; or bit 20 is not 0; or P=0 with W=0.
- R9: On a valid encoding, `flag_unpred` pulses with `op_done`, with no write and no base update, when any of these holds:
  - Either format: either data register is 15; or a base update is due and the base equals either data register.
  - 32-bit format only: the first register (bits 15:12) is odd; P=0 with W=1; or a base update is due with base 15.
  - Wide format only: the base is 15 in any mode.
- R10: With `in_cond_ok` low and no flag raised, the unit makes no write and no base update and pulses `op_done` with both flags low. Any flag is reported whatever the condition input.
- R11: A raised `mem_req` holds, with address and data unchanged, until the edge where `mem_ack` is sampled high.
- R12: The base index is bits 19:16 and the first data index is bits 15:12 in both formats. The second data index is the first plus one in the 32-bit format and bits 11:8 in the wide format.
- R13: After reset, `in_ready` is high and `mem_req`, `wb_en`, `op_done` and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction can be taken |
| in_instr | input | 32 | Instruction word |
| in_wide | input | 1 | 1 = wide format, 0 = 32-bit conditional format |
| in_cond_ok | input | 1 | Condition passed for this instruction |
| in_big_endian | input | 1 | Big-endian data ordering |
| rf_first_idx | output | 4 | Read index, first data register |
| rf_first_data | input | 32 | Read data, first data register |
| rf_second_idx | output | 4 | Read index, second data register |
| rf_second_data | input | 32 | Read data, second data register |
| rf_base_idx | output | 4 | Read index, base register |
| rf_base_data | input | 32 | Read data, base register |
| mem_req | output | 1 | Store request |
| mem_ack | input | 1 | Store acknowledge |
| mem_dword | output | 1 | 1 = 64-bit write, 0 = 32-bit write |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables |
| wb_en | output | 1 | Base register update |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | New base value |
| op_done | output | 1 | Instruction finished (one-cycle pulse) |
| flag_bad_enc | output | 1 | Encoding is not this store |
| flag_unpred | output | 1 | Unpredictable register combination |

## Verification
The instruction is taken at one edge and decoded in the next cycle. A rejected instruction (bad, unpredictable or condition-failed) therefore shows `op_done` one cycle after acceptance. The first write request appears one cycle after acceptance. The bench holds each acknowledge back by 0, 1 or 2 cycles, so a single 64-bit write finishes 2 + delay cycles after acceptance and a split pair 3 + 2×delay cycles after. Every comparison is made at a falling edge, with the expected cycle worked out from that schedule. The sweep covers every P/U/W combination in both formats, data and base registers chosen to collide, both endian settings and every single-bit corruption of a valid word.

// File: rtl/pairstore_pkg.sv
package pairstore_pkg;

  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 4;
  localparam int IMM_W   = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SEND1 = 2'd2,
    ST_SEND2 = 2'd3
  } pst_state_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rt2;
    logic [IMM_W-1:0]  imm;
    logic              pre;
    logic              up;
    logic              wback;
    logic              bad_enc;
    logic              unpred;
  } pst_dec_t;

endpackage

// File: rtl/pairstore_decode.sv
module pairstore_decode
  import pairstore_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               wide,
  output pst_dec_t           dec
);

  localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};

  logic p_bit, u_bit, w_bit;
  logic narrow_ok, wide_ok, legal;
  logic [RIDX_W-1:0] rn, rt, rt2;
  logic wb, clash, narrow_odd;

  always_comb begin
    p_bit = instr[24];
    u_bit = instr[23];
    w_bit = instr[21];
    rn    = instr[19:16];
    rt    = instr[15:12];
    rt2   = wide ? instr[11:8] : (rt + 1'b1);

    narrow_ok = (instr[31:28] != 4'hF) && (instr[27:25] == 3'b000) &&
                instr[22] && !instr[20] && (instr[7:4] == 4'hF);
    wide_ok   = (instr[31:25] == 7'b1110100) && instr[22] && !instr[20] &&
                (p_bit || w_bit);
    legal     = wide ? wide_ok : narrow_ok;

    wb        = wide ? w_bit : (!p_bit || w_bit);
    clash     = wb && ((rn == rt) || (rn == rt2));
    narrow_odd = rt[0] || (!p_bit && w_bit) || (wb && (rn == PC_IDX));

    dec.rn      = rn;
    dec.rt      = rt;
    dec.rt2     = rt2;
    dec.imm     = wide ? {instr[7:0], 2'b00} : {2'b00, instr[11:8], instr[3:0]};
    dec.pre     = p_bit;
    dec.up      = u_bit;
    dec.wback   = wb;
    dec.bad_enc = !legal;
    dec.unpred  = legal && (clash || (rt == PC_IDX) || (rt2 == PC_IDX) ||
                            (wide ? (rn == PC_IDX) : narrow_odd));
  end

endmodule

// File: rtl/pairstore_agen.sv
module pairstore_agen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 10
) (
  input  logic [XLEN-1:0]   base,
  input  logic [IMM_W-1:0]  imm,
  input  logic              up,
  input  logic              pre,
  input  logic              big_endian,
  input  logic [XLEN-1:0]   word_a,
  input  logic [XLEN-1:0]   word_b,
  output logic [XLEN-1:0]   off_addr,
  output logic [XLEN-1:0]   acc_addr,
  output logic              aligned,
  output logic [2*XLEN-1:0] pair_data
);

  localparam int PAIR_BYTES = (2 * XLEN) / 8;
  localparam int ALIGN_BITS = $clog2(PAIR_BYTES);

  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext  = {{(XLEN-IMM_W){1'b0}}, imm};
    off_addr = up ? (base + imm_ext) : (base - imm_ext);
    acc_addr = pre ? off_addr : base;
    aligned  = (acc_addr[ALIGN_BITS-1:0] == '0);
  end

  // Lane g carries the first register when its index matches the byte order.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign pair_data[g*XLEN +: XLEN] = ((g == 1) ^ big_endian) ? word_b : word_a;
  end

endmodule

// File: rtl/pairstore_unit.sv
module pairstore_unit
  import pairstore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSTR_W-1:0]   in_instr,
  input  logic                 in_wide,
  input  logic                 in_cond_ok,
  input  logic                 in_big_endian,
  output logic [RIDX_W-1:0]    rf_first_idx,
  input  logic [XLEN-1:0]      rf_first_data,
  output logic [RIDX_W-1:0]    rf_second_idx,
  input  logic [XLEN-1:0]      rf_second_data,
  output logic [RIDX_W-1:0]    rf_base_idx,
  input  logic [XLEN-1:0]      rf_base_data,
  output logic                 mem_req,
  input  logic                 mem_ack,
  output logic                 mem_dword,
  output logic [XLEN-1:0]      mem_addr,
  output logic [2*XLEN-1:0]    mem_wdata,
  output logic [(2*XLEN)/8-1:0] mem_be,
  output logic                 wb_en,
  output logic [RIDX_W-1:0]    wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic                 op_done,
  output logic                 flag_bad_enc,
  output logic                 flag_unpred
);

  localparam int BE_W  = (2 * XLEN) / 8;
  localparam logic [BE_W-1:0] BE_PAIR = {BE_W{1'b1}};
  localparam logic [BE_W-1:0] BE_WORD = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

  pst_state_e         state;
  logic [INSTR_W-1:0] instr_q;
  logic               wide_q, cond_q, bigend_q;
  logic [XLEN-1:0]    second_q, addr2_q;
  logic               split_q, wb_pend_q;

  pst_dec_t           dec;
  logic [XLEN-1:0]    off_addr, acc_addr;
  logic               aligned;
  logic [2*XLEN-1:0]  pair_data;
  logic               skip;

  pairstore_decode u_decode (
    .instr (instr_q),
    .wide  (wide_q),
    .dec   (dec)
  );

  pairstore_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base       (rf_base_data),
    .imm        (dec.imm),
    .up         (dec.up),
    .pre        (dec.pre),
    .big_endian (bigend_q),
    .word_a     (rf_first_data),
    .word_b     (rf_second_data),
    .off_addr   (off_addr),
    .acc_addr   (acc_addr),
    .aligned    (aligned),
    .pair_data  (pair_data)
  );

  assign rf_first_idx  = dec.rt;
  assign rf_second_idx = dec.rt2;
  assign rf_base_idx   = dec.rn;
  assign in_ready      = (state == ST_IDLE);
  assign skip          = dec.bad_enc || dec.unpred || !cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      instr_q      <= '0;
      wide_q       <= 1'b0;
      cond_q       <= 1'b0;
      bigend_q     <= 1'b0;
      second_q     <= '0;
      addr2_q      <= '0;
      split_q      <= 1'b0;
      wb_pend_q    <= 1'b0;
      mem_req      <= 1'b0;
      mem_dword    <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_be       <= '0;
      wb_en        <= 1'b0;
      wb_idx       <= '0;
      wb_data      <= '0;
      op_done      <= 1'b0;
      flag_bad_enc <= 1'b0;
      flag_unpred  <= 1'b0;
    end else begin
      op_done      <= 1'b0;
      wb_en        <= 1'b0;
      flag_bad_enc <= 1'b0;
      flag_unpred  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            instr_q  <= in_instr;
            wide_q   <= in_wide;
            cond_q   <= in_cond_ok;
            bigend_q <= in_big_endian;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          wb_idx    <= dec.rn;
          wb_data   <= off_addr;
          wb_pend_q <= dec.wback;
          if (skip) begin
            op_done      <= 1'b1;
            flag_bad_enc <= dec.bad_enc;
            flag_unpred  <= dec.unpred;
            state        <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= acc_addr;
            split_q  <= !aligned;
            second_q <= rf_second_data;
            addr2_q  <= acc_addr + WORD_STEP;
            if (aligned) begin
              mem_dword <= 1'b1;
              mem_wdata <= pair_data;
              mem_be    <= BE_PAIR;
            end else begin
              mem_dword <= 1'b0;
              mem_wdata <= {{XLEN{1'b0}}, rf_first_data};
              mem_be    <= BE_WORD;
            end
            state <= ST_SEND1;
          end
        end
        ST_SEND1, ST_SEND2: begin
          if (mem_ack) begin
            if (state == ST_SEND1 && split_q) begin
              mem_addr  <= addr2_q;
              mem_wdata <= {{XLEN{1'b0}}, second_q};
              state     <= ST_SEND2;
            end else begin
              mem_req <= 1'b0;
              wb_en   <= wb_pend_q;
              op_done <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !mem_req);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_dword_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_dword) |-> (mem_addr[2:0] == 3'b000));

  assert_split_step_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req && mem_ack && !mem_dword)) |->
      (mem_addr == $past(mem_addr) + WORD_STEP));

  assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (op_done && $past(mem_ack)));

  assert_flag_no_store_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_unpred || flag_bad_enc) |-> (op_done && !wb_en && !mem_req));

endmodule

// File: tb/pairstore_unit_bench.sv
module pairstore_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        in_wide = 1'b0;
  logic        in_cond_ok = 1'b1;
  logic        in_big_endian = 1'b0;
  logic [3:0]  rf_first_idx, rf_second_idx, rf_base_idx;
  logic [31:0] rf_first_data, rf_second_data, rf_base_data;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic        mem_dword;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;
  logic        op_done, flag_bad_enc, flag_unpred;

  int n_checks = 0;
  int n_fails  = 0;
  int op_cnt   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rv(input logic [3:0] i);
    logic [15:0] lo;
    lo = 16'h1000 + 16'(i) * 16'd3;
    return {8'hA5, 4'h0, i, lo};
  endfunction

  assign rf_first_data  = rv(rf_first_idx);
  assign rf_second_data = rv(rf_second_idx);
  assign rf_base_data   = rv(rf_base_idx);

  pairstore_unit u_pairstore_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_wide(in_wide), .in_cond_ok(in_cond_ok),
    .in_big_endian(in_big_endian),
    .rf_first_idx(rf_first_idx), .rf_first_data(rf_first_data),
    .rf_second_idx(rf_second_idx), .rf_second_data(rf_second_data),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .op_done(op_done), .flag_bad_enc(flag_bad_enc), .flag_unpred(flag_unpred)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, op_cnt, act, exp);
    end
  endtask

  // expected results
  logic        e_bad, e_unp, e_wb;
  int          e_nw, e_cyc;
  logic [31:0] e_addr [2];
  logic [63:0] e_data [2];
  logic [7:0]  e_be   [2];
  logic        e_dw   [2];
  logic [3:0]  e_wbidx;
  logic [31:0] e_wbdata;

  task automatic model(input logic [31:0] w, input logic wd, input logic c, input logic b, input int dly);
    logic p, u, wb_mode, legal, unp;
    logic [3:0] rn, t, t2;
    logic [31:0] base, imm, off, addr;
    p = w[24]; u = w[23];
    rn = w[19:16]; t = w[15:12];
    if (wd) begin
      legal = (w[31:25] == 7'b1110100) && w[22] && !w[20] && (w[24] || w[21]);
      t2 = w[11:8];
      imm = 32'(w[7:0]) * 4;
      wb_mode = w[21];
      unp = (rn == 15) || (t == 15) || (t2 == 15) || (wb_mode && (rn == t || rn == t2));
    end else begin
      legal = (w[31:28] != 4'hF) && (w[27:25] == 0) && w[22] && !w[20] && (w[7:4] == 4'hF);
      t2 = t + 4'd1;
      imm = 32'(w[11:8]) * 16 + 32'(w[3:0]);
      wb_mode = !w[24] || w[21];
      unp = t[0] || (!w[24] && w[21]) || (t == 15) || (t2 == 15) ||
            (wb_mode && (rn == 15 || rn == t || rn == t2));
    end
    e_bad = !legal;
    e_unp = legal && unp;
    e_nw = 0; e_wb = 0; e_cyc = 1;
    base = rv(rn);
    off  = u ? base + imm : base - imm;
    addr = p ? off : base;
    e_wbidx = rn; e_wbdata = off;
    if (!e_bad && !e_unp && c) begin
      e_wb = wb_mode;
      if (addr % 8 == 0) begin
        e_nw = 1; e_cyc = 2 + dly;
        e_addr[0] = addr; e_dw[0] = 1; e_be[0] = 8'hFF;
        e_data[0] = b ? {rv(t), rv(t2)} : {rv(t2), rv(t)};
      end else begin
        e_nw = 2; e_cyc = 3 + 2*dly;
        e_addr[0] = addr;     e_dw[0] = 0; e_be[0] = 8'h0F; e_data[0] = {32'h0, rv(t)};
        e_addr[1] = addr + 4; e_dw[1] = 0; e_be[1] = 8'h0F; e_data[1] = {32'h0, rv(t2)};
      end
    end
  endtask

  task automatic run_op(input logic [31:0] w, input logic wd, input logic c, input logic b, input int dly);
    int nw, wait_cnt, cyc_done;
    bit seen;
    logic [31:0] g_addr [2];
    logic [63:0] g_data [2];
    logic [7:0]  g_be   [2];
    logic        g_dw   [2];
    logic g_bad, g_unp, g_wb, g_rdy;
    logic [3:0] g_wbidx;
    logic [31:0] g_wbdata;
    model(w, wd, c, b, dly);
    @(negedge clk);
    in_valid = 1; in_instr = w; in_wide = wd; in_cond_ok = c; in_big_endian = b;
    @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R1 ready low while busy", 64'(in_ready), 64'd0);
    nw = 0; wait_cnt = 0; seen = 0; cyc_done = -1;
    g_bad = 0; g_unp = 0; g_wb = 0; g_rdy = 0; g_wbidx = 0; g_wbdata = 0;
    for (int cyc = 0; cyc < 40 && !seen; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_ack = 0;
      if (op_done) begin
        seen = 1; cyc_done = cyc;
        g_bad = flag_bad_enc; g_unp = flag_unpred; g_wb = wb_en;
        g_wbidx = wb_idx; g_wbdata = wb_data; g_rdy = in_ready;
      end else if (mem_req) begin
        if (wait_cnt == dly) begin
          if (nw < 2) begin
            g_addr[nw] = mem_addr; g_data[nw] = mem_wdata;
            g_be[nw] = mem_be; g_dw[nw] = mem_dword;
          end
          nw++; mem_ack = 1; wait_cnt = 0;
        end else wait_cnt++;
      end
    end
    mem_ack = 0;
    chk(seen, "R7 done pulse seen", 64'(seen), 64'd1);
    chk(cyc_done == e_cyc, "R7 done latency", 64'(cyc_done), 64'(e_cyc));
    chk(g_rdy == 1, "R1 ready at done", 64'(g_rdy), 64'd1);
    chk(g_bad == e_bad, "R8 bad encoding flag", 64'(g_bad), 64'(e_bad));
    chk(g_unp == e_unp, "R9 unpredictable flag", 64'(g_unp), 64'(e_unp));
    chk(nw == e_nw, "R10 write count", 64'(nw), 64'(e_nw));
    chk(g_wb == e_wb, "R2 writeback enable", 64'(g_wb), 64'(e_wb));
    if (e_wb && g_wb) begin
      chk(g_wbidx == e_wbidx, "R12 writeback index", 64'(g_wbidx), 64'(e_wbidx));
      chk(g_wbdata == e_wbdata, "R4 writeback value", 64'(g_wbdata), 64'(e_wbdata));
    end
    if (nw == e_nw) begin
      for (int k = 0; k < e_nw; k++) begin
        chk(g_addr[k] == e_addr[k], "R4 R3 write address", 64'(g_addr[k]), 64'(e_addr[k]));
        chk(g_data[k] == e_data[k], "R5 R6 R12 write data", g_data[k], e_data[k]);
        chk(g_be[k] == e_be[k], "R6 byte enables", 64'(g_be[k]), 64'(e_be[k]));
        chk(g_dw[k] == e_dw[k], "R5 write size", 64'(g_dw[k]), 64'(e_dw[k]));
      end
    end
    op_cnt++;
  endtask

  function automatic logic [31:0] enc_narrow(input logic p, u, w, input logic [3:0] rn, rt, input logic [7:0] imm);
    return {4'hE, 3'b000, p, u, 1'b1, w, 1'b0, rn, rt, imm[7:4], 4'hF, imm[3:0]};
  endfunction

  function automatic logic [31:0] enc_wide(input logic p, u, w, input logic [3:0] rn, rt, rt2, input logic [7:0] imm);
    return {7'b1110100, p, u, 1'b1, w, 1'b0, rn, rt, rt2, imm};
  endfunction

  initial begin
    logic [3:0] rt_set [4];
    logic [3:0] rn_set [4];
    logic [7:0] imm_set [3];
    logic [31:0] w;
    rt_set  = '{4'd0, 4'd3, 4'd6, 4'd14};
    rn_set  = '{4'd1, 4'd6, 4'd9, 4'd15};
    imm_set = '{8'h00, 8'h05, 8'hF8};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(in_ready == 1, "R13 ready after reset", 64'(in_ready), 64'd1);
    chk(mem_req == 0, "R13 no request after reset", 64'(mem_req), 64'd0);
    chk(op_done == 0 && wb_en == 0, "R13 no done/wb after reset", 64'({op_done, wb_en}), 64'd0);
    chk(flag_bad_enc == 0 && flag_unpred == 0, "R13 flags low after reset",
        64'({flag_bad_enc, flag_unpred}), 64'd0);

    // main sweep over both formats, all P/U/W, register collisions, offsets, endianness
    for (int fmt = 0; fmt < 2; fmt++)
      for (int puw = 0; puw < 8; puw++)
        for (int ti = 0; ti < 4; ti++)
          for (int ni = 0; ni < 4; ni++)
            for (int ii = 0; ii < 3; ii++)
              for (int be = 0; be < 2; be++) begin
                if (fmt == 1)
                  w = enc_wide(puw[2], puw[1], puw[0], rn_set[ni], rt_set[ti],
                               rt_set[ti] ^ 4'h9, imm_set[ii]);
                else
                  w = enc_narrow(puw[2], puw[1], puw[0], rn_set[ni], rt_set[ti], imm_set[ii]);
                run_op(w, fmt[0], (op_cnt % 7) != 3, be[0], op_cnt % 3);
              end

    // R8 every single-bit corruption of a legal word, both formats
    for (int bp = 0; bp < 32; bp++) begin
      w = enc_narrow(1'b1, 1'b1, 1'b0, 4'd2, 4'd4, 8'h10);
      w[bp] = ~w[bp];
      run_op(w, 1'b0, 1'b1, 1'b0, 1);
      w = enc_wide(1'b1, 1'b0, 1'b1, 4'd2, 4'd4, 4'd7, 8'h03);
      w[bp] = ~w[bp];
      run_op(w, 1'b1, 1'b1, 1'b1, 0);
    end
    // R8 cond field of all ones
    w = enc_narrow(1'b1, 1'b1, 1'b0, 4'd2, 4'd4, 8'h10);
    w[31:28] = 4'hF;
    run_op(w, 1'b0, 1'b1, 1'b0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", op_cnt, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule